// File: doc/BRIEF.md
# Packed 16-bit Lane Multiply and Shift Unit

This unit multiplies the 16-bit lanes of two packed source words and produces a packed result word. It has two families of operation. The widening operations multiply one pair of lanes per 32-bit half of the result and keep the full 32-bit signed product. One operation uses the even-numbered lane pairs and the other uses the odd-numbered lane pairs. The multiply-shift operations multiply every lane pair, either signed or unsigned. Each 32-bit product is shifted right by one of four fixed amounts, and the low 16 bits of the shifted value are written to the matching result lane.

The unit is a two-stage pipeline. The first stage registers the raw lane products. The second stage applies the shift or widening selection, then packs and registers the result. A new operation can be accepted on every cycle. There is no back-pressure: `in_valid` presents an operation and `out_valid` marks its result two clock edges later. The result register holds its value between results.

Top module: `lane_mulshift_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: An operation presented with `in_valid` high at one rising edge yields `out_valid` high after exactly two rising edges. Back-to-back operations yield back-to-back results in order. Cycles with `in_valid` low yield `out_valid` low.
- R3: `in_op` = 2'b00 (widening, even lanes): `out_data[31:0]` is the signed 32-bit product of lane 0 of `in_a` and `in_b`, and `out_data[63:32]` is the signed product of lane 2. Lane n occupies bits 16n+15:16n.
- R4: `in_op` = 2'b01 (widening, odd lanes): `out_data[31:0]` is the signed product of lane 1, and `out_data[63:32]` is the signed product of lane 3.
- R5: `in_op` = 2'b10 (signed multiply-shift): each result lane n is the low 16 bits of the signed 32-bit product of lane n, shifted right arithmetically by the selected amount.
- R6: `in_op` = 2'b11 (unsigned multiply-shift): each result lane n is the low 16 bits of the unsigned 32-bit product of lane n, shifted right logically by the selected amount.
- R7: `in_shift` selects the right-shift amount of the multiply-shift operations: 2'b00 = 0, 2'b01 = 7, 2'b10 = 15, 2'b11 = 16.
- R8: `in_shift` has no effect on the result of the widening operations.
- R9: On cycles where `out_valid` is low, `out_data` keeps the value of the most recent result, or zero if there has been no result since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 2 | Operation select (see R3 to R6) |
| in_shift | input | 2 | Shift amount select for the multiply-shift operations |
| in_a | input | 64 | First packed source, four 16-bit lanes |
| in_b | input | 64 | Second packed source, four 16-bit lanes |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 64 | Packed result |

## Verification
The bench builds the unit with its default parameters: four 16-bit lanes, which gives a 64-bit word. With these values the shift amounts come out as exactly 0, 7, 15 and 16. Both widening lane selections and the full-range corner products are therefore reachable, including the most negative value squared and all-ones unsigned operands. Random operations are issued on most cycles, with gaps between them, so the bench exercises back-to-back issue, the two-edge latency and the holding of `out_data` across idle cycles.

// File: rtl/lms_pkg.sv
package lms_pkg;
   typedef enum logic [1:0] {
      LMS_WIDE_EVEN   = 2'b00,
      LMS_WIDE_ODD    = 2'b01,
      LMS_MS_SIGNED   = 2'b10,
      LMS_MS_UNSIGNED = 2'b11
   } lms_op_e;

   // widening operations have op bit 1 clear; bit 0 then picks the odd lanes
   function automatic logic op_is_wide(input logic [1:0] op);
      return ~op[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] op);
      return (op != LMS_MS_UNSIGNED);
   endfunction
endpackage

// File: rtl/lms_lane_mul.sv
module lms_lane_mul #(
   parameter int W = 16
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           is_signed,
   output logic [2*W-1:0] prod
);
   localparam int EW = W + 1;
   localparam int FW = 2 * EW;

   logic signed [EW-1:0] a_ext;
   logic signed [EW-1:0] b_ext;
   logic signed [FW-1:0] full;

   always_comb begin
      a_ext = {is_signed & a[W-1], a};
      b_ext = {is_signed & b[W-1], b};
      full  = a_ext * b_ext;
      prod  = full[2*W-1:0];
   end
endmodule

// File: rtl/lms_lane_shift.sv
module lms_lane_shift #(
   parameter int W   = 16,
   parameter int SH1 = 7,
   parameter int SH2 = 15,
   parameter int SH3 = 16
) (
   input  logic [2*W-1:0] prod,
   input  logic           is_signed,
   input  logic [1:0]     sel,
   output logic [W-1:0]   res
);
   localparam int PW = 2 * W;
   localparam int AW = $clog2(PW) + 1;

   logic [AW-1:0] amt;
   logic [PW-1:0] shifted;

   always_comb begin
      unique case (sel)
         2'b00:   amt = '0;
         2'b01:   amt = AW'(SH1);
         2'b10:   amt = AW'(SH2);
         default: amt = AW'(SH3);
      endcase
      if (is_signed) shifted = $signed(prod) >>> amt;
      else           shifted = prod >> amt;
      res = shifted[W-1:0];
   end
endmodule

// File: rtl/lms_pack.sv
module lms_pack #(
   parameter int W     = 16,
   parameter int LANES = 4
) (
   input  logic [LANES*2*W-1:0] prods,
   input  logic [LANES*W-1:0]   shifted,
   input  logic [1:0]           op,
   output logic [LANES*W-1:0]   data
);
   import lms_pkg::*;

   localparam int PW    = 2 * W;
   localparam int HALVES = LANES / 2;

   logic [LANES*W-1:0] wide;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_comb begin
         if (op[0]) wide[h*PW +: PW] = prods[(2*h+1)*PW +: PW];
         else       wide[h*PW +: PW] = prods[(2*h)*PW +: PW];
      end
   end

   assign data = op_is_wide(op) ? wide : shifted;
endmodule

// File: rtl/lane_mulshift_unit.sv
module lane_mulshift_unit #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [1:0]              in_op,
   input  logic [1:0]              in_shift,
   input  logic [LANE_W*LANES-1:0] in_a,
   input  logic [LANE_W*LANES-1:0] in_b,
   output logic                    out_valid,
   output logic [LANE_W*LANES-1:0] out_data
);
   import lms_pkg::*;

   localparam int DATA_W = LANE_W * LANES;
   localparam int PROD_W = 2 * LANE_W;
   localparam int SH_MID = LANE_W / 2 - 1;
   localparam int SH_HI  = LANE_W - 1;
   localparam int SH_TOP = LANE_W;

   initial begin : param_chk
      assert (LANES >= 2 && LANES % 2 == 0)
         else $error("LANES must be even and at least 2");
      assert (LANE_W >= 4 && LANE_W % 2 == 0)
         else $error("LANE_W must be even and at least 4");
   end

   // stage 0: lane multipliers on the raw inputs
   logic [LANES*PROD_W-1:0] prod_c;
   logic                    mul_signed;

   assign mul_signed = op_is_signed(in_op);

   for (genvar i = 0; i < LANES; i++) begin : g_mul
      lms_lane_mul #(.W(LANE_W)) u_mul (
         .a         (in_a[i*LANE_W +: LANE_W]),
         .b         (in_b[i*LANE_W +: LANE_W]),
         .is_signed (mul_signed),
         .prod      (prod_c[i*PROD_W +: PROD_W])
      );
   end

   // stage 1 registers
   logic                    s1_valid;
   logic [LANES*PROD_W-1:0] s1_prod;
   logic [1:0]              s1_op;
   logic [1:0]              s1_shift;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_prod  <= '0;
         s1_op    <= '0;
         s1_shift <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_prod  <= prod_c;
            s1_op    <= in_op;
            s1_shift <= in_shift;
         end
      end
   end

   // stage 2: per-lane shift and truncation, then packing
   logic [DATA_W-1:0] shifted_c;
   logic [DATA_W-1:0] packed_c;
   logic              s1_signed;

   assign s1_signed = op_is_signed(s1_op);

   for (genvar i = 0; i < LANES; i++) begin : g_shift
      lms_lane_shift #(
         .W   (LANE_W),
         .SH1 (SH_MID),
         .SH2 (SH_HI),
         .SH3 (SH_TOP)
      ) u_shift (
         .prod      (s1_prod[i*PROD_W +: PROD_W]),
         .is_signed (s1_signed),
         .sel       (s1_shift),
         .res       (shifted_c[i*LANE_W +: LANE_W])
      );
   end

   lms_pack #(.W(LANE_W), .LANES(LANES)) u_pack (
      .prods   (s1_prod),
      .shifted (shifted_c),
      .op      (s1_op),
      .data    (packed_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_data <= packed_c;
      end
   end
endmodule

// File: rtl/lane_mulshift_chk.sv
module lane_mulshift_chk #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic [1:0]              in_op,
   input logic [LANE_W*LANES-1:0] in_a,
   input logic                    out_valid,
   input logic [LANE_W*LANES-1:0] out_data
);
   logic [1:0] seen;

   always_ff @(posedge clk) begin
      if (rst)               seen <= '0;
      else if (seen != 2'd3) seen <= seen + 2'd1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_data == '0));

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      (seen == 2'd3) |-> (out_valid == $past(in_valid, 2)));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (seen >= 2'd2 && !out_valid) |-> $stable(out_data));

   // R3
   even_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (seen == 2'd3 && out_valid && $past(in_op, 2) == 2'b00
       && $past(in_a[LANE_W-1:0], 2) == '0)
      |-> (out_data[2*LANE_W-1:0] == '0));
endmodule

bind lane_mulshift_unit lane_mulshift_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_a      (in_a),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/lane_mulshift_unit_tb.sv
module lane_mulshift_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = '0;
   logic [1:0]  in_shift = '0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic [63:0] out_data;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   lane_mulshift_unit u_dut (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_op (in_op),
      .in_shift (in_shift), .in_a (in_a), .in_b (in_b),
      .out_valid (out_valid), .out_data (out_data)
   );

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] op, input logic [1:0] sh);
      logic [63:0] r;
      longint pa, pb, p;
      int s;
      r = '0;
      if (!op[1]) begin
         for (int h = 0; h < 2; h++) begin
            int ln;
            ln = 2 * h + int'(op[0]);
            pa = longint'($signed(a[16*ln +: 16]));
            pb = longint'($signed(b[16*ln +: 16]));
            p  = pa * pb;
            r[32*h +: 32] = p[31:0];
         end
      end else begin
         s = (sh == 2'd0) ? 0 : (sh == 2'd1) ? 7 : (sh == 2'd2) ? 15 : 16;
         for (int i = 0; i < 4; i++) begin
            if (!op[0]) begin
               pa = longint'($signed(a[16*i +: 16]));
               pb = longint'($signed(b[16*i +: 16]));
               p  = (pa * pb) >>> s;
            end else begin
               pa = longint'({48'd0, a[16*i +: 16]});
               pb = longint'({48'd0, b[16*i +: 16]});
               p  = (pa * pb) >> s;
            end
            r[16*i +: 16] = p[15:0];
         end
      end
      return r;
   endfunction

   function automatic string op_tag(input logic [1:0] op, input logic [1:0] sh);
      case (op)
         2'b00:   return (sh != 0) ? "R3 R8" : "R3";
         2'b01:   return (sh != 0) ? "R4 R8" : "R4";
         2'b10:   return "R5 R7";
         default: return "R6 R7";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expectation pipeline: p1 = driven one negedge ago, p2 = two ago
   bit          p1_v = 0, p2_v = 0;
   logic [63:0] p1_d = '0, p2_d = '0;
   string       p1_t = "", p2_t = "";
   logic [63:0] last_d = '0;

   task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] op, input logic [1:0] sh);
      @(negedge clk);
      check(out_valid == p2_v, "R2 valid", 64'(out_valid), 64'(p2_v));
      if (p2_v) begin
         check(out_data == p2_d, p2_t, out_data, p2_d);
         last_d = p2_d;
      end else begin
         check(out_data == last_d, "R9 hold", out_data, last_d);
      end
      p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
      p1_v = v;
      p1_d = model(a, b, op, sh);
      p1_t = op_tag(op, sh);
      in_valid = v; in_a = a; in_b = b; in_op = op; in_shift = sh;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
      check(out_data == '0, "R1 data", out_data, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R1 post", out_data, 64'd0);

      // directed corners
      for (int op = 0; op < 4; op++) begin
         for (int sh = 0; sh < 4; sh++) begin
            step(1, {4{16'h8000}}, {4{16'h8000}}, 2'(op), 2'(sh));
            step(1, {4{16'hFFFF}}, {4{16'hFFFF}}, 2'(op), 2'(sh));
            step(1, 64'h7FFF_8000_0001_FFFF, 64'h8000_7FFF_FFFF_0003, 2'(op), 2'(sh));
         end
      end
      // R8: identical operands, shift varied, widening
      for (int sh = 0; sh < 4; sh++)
         step(1, 64'h1234_8765_FEDC_0F0F, 64'hA5A5_5A5A_0102_F00D, 2'b01, 2'(sh));
      step(0, '0, '0, 2'b00, 2'b00);
      step(0, '0, '0, 2'b00, 2'b00);

      // random traffic with gaps
      for (int n = 0; n < 600; n++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         step(($urandom % 4) != 0, ra, rb, 2'($urandom), 2'($urandom));
      end
      step(0, '0, '0, 2'b00, 2'b00);
      step(0, '0, '0, 2'b00, 2'b00);
      step(0, '0, '0, 2'b00, 2'b00);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule